// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block arbitrates among the request lines of one interrupt controller. Each cycle it looks at the pending requests that are not masked and picks the one with the highest priority. It then compares that choice with the interrupts already in service. A grant is raised only when the chosen request outranks every in-service interrupt. The result is a valid flag and the number of the winning line. An acknowledge input moves the granted line into the in-service register, which the block holds itself.

Priority is circular and is set by a base register, which names the line with the highest priority. The line just before the base has the lowest priority. Software moves the base with one-cycle commands. A command can name the lowest line directly, or it can rotate as part of an end-of-interrupt. An automatic mode makes every non-specific end-of-interrupt rotate, so the line just serviced drops to the bottom. The default order, with line 0 highest and the last line lowest, is the case where the base stays at zero.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the in-service register is clear, automatic rotation is off and the base is one past RESET_LOWEST (default 7, so base 0). With all lines requesting, line 0 is granted.
- R2: The grant is combinational and follows the priority order base, base+1, …, wrapping modulo NUM_IRQ. When several lines request together, only the first line in that order is granted.
- R3: A line whose mask bit is 1 never takes part in arbitration. When every requesting line is masked, no grant is driven.
- R4: A request is granted only if it comes strictly earlier in the current order than every set in-service bit. An equal or later position drives no grant. An earlier request is granted while a later one is in service (nesting).
- R5: When ack_i is 1 and a grant is driven, the granted bit of isr_o is set at the next clock edge. When ack_i is 1 and no grant is driven, nothing changes.
- R6: cmd_op_i code 2 (specific EOI) clears isr_o bit cmd_irq_i and leaves the base unchanged.
- R7: cmd_op_i code 1 (non-specific EOI) clears the set in-service bit that comes first in the current order. If no in-service bit is set, nothing happens.
- R8: cmd_op_i code 5 makes line cmd_irq_i the lowest priority: the base becomes cmd_irq_i+1 modulo NUM_IRQ. The in-service register is not touched.
- R9: cmd_op_i code 4 clears isr_o bit cmd_irq_i and sets the base to cmd_irq_i+1.
- R10: cmd_op_i code 3 clears the first set in-service bit in the current order and sets the base to that line plus one.
- R11: cmd_op_i code 6 turns automatic rotation on and code 7 turns it off. While it is on, code 1 behaves like code 3. While it is off, code 1 leaves the base alone. Code 0 does nothing.
- R12: With automatic rotation on, every line requesting all the time, and each grant acknowledged and then ended with code 1, the lines are granted in the order 0, 1, …, NUM_IRQ-1 and then again from 0. No line is served twice before every other line has been served once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_IRQ (8) | Request lines, one bit per line |
| mask_i | input | NUM_IRQ (8) | Mask bits; 1 removes the line from arbitration |
| ack_i | input | 1 | Acknowledge: move the current grant into service |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_op_i | input | 3 | Command code (0 to 7, see the requirements) |
| cmd_irq_i | input | ID_W (3) | Line named by specific commands |
| grant_valid_o | output | 1 | A request is granted |
| grant_id_o | output | ID_W (3) | Number of the granted line |
| isr_o | output | NUM_IRQ (8) | In-service register |

## Verification
The assertions assume the following about the inputs. Request and mask bits are steady around the clock edge. ack_i matters only when a grant is present. At most one command arrives per cycle, and when a specific end-of-interrupt and an acknowledge name the same line in the same cycle, the set wins. The stimulus drives every input half a cycle away from the active edge and issues commands as single-cycle pulses. In the rotation tests it sends ack_i only in cycles where a grant is expected, so the in-service register follows known values and every rotation can be seen through the grants that follow.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   // Command codes applied on cmd_op_i when cmd_valid_i is high.
   typedef enum logic [2:0] {
      OP_NOP       = 3'd0,
      OP_EOI_NS    = 3'd1,
      OP_EOI_SPEC  = 3'd2,
      OP_ROT_NS    = 3'd3,
      OP_ROT_SPEC  = 3'd4,
      OP_SET_LOW   = 3'd5,
      OP_AUTO_ON   = 3'd6,
      OP_AUTO_OFF  = 3'd7
   } prio_op_e;

endpackage

// File: rtl/irq_rotate.sv
// Circular re-indexing: position p of the output holds input line (base+p).
module irq_rotate #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  vec_i,
   input  logic [IW-1:0] base_i,
   output logic [N-1:0]  rot_o
);
   for (genvar gp = 0; gp < N; gp++) begin : g_pos
      logic [IW-1:0] src;
      assign src       = base_i + IW'(gp);
      assign rot_o[gp] = vec_i[src];
   end
endmodule

// File: rtl/irq_first_set.sv
// Finds the lowest-numbered set bit, i.e. the first position in the order.
module irq_first_set #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  vec_i,
   output logic          any_o,
   output logic [IW-1:0] pos_o
);
   always_comb begin
      any_o = 1'b0;
      pos_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            any_o = 1'b1;
            pos_o = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_isr_bank.sv
// In-service register: one clear and one set per cycle, set wins on overlap.
module irq_isr_bank #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en_i,
   input  logic [IW-1:0] set_id_i,
   input  logic          clr_en_i,
   input  logic [IW-1:0] clr_id_i,
   output logic [N-1:0]  isr_o
);
   logic [N-1:0] set_mask;
   logic [N-1:0] clr_mask;

   for (genvar gb = 0; gb < N; gb++) begin : g_dec
      assign set_mask[gb] = set_en_i && (set_id_i == IW'(gb));
      assign clr_mask[gb] = clr_en_i && (clr_id_i == IW'(gb));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_o <= '0;
      else        isr_o <= (isr_o & ~clr_mask) | set_mask;
   end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import irq_prio_pkg::*;
#(
   parameter int NUM_IRQ     = 8,
   parameter int ID_W        = $clog2(NUM_IRQ),
   parameter int RESET_LOWEST = NUM_IRQ - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] req_i,
   input  logic [NUM_IRQ-1:0] mask_i,
   input  logic               ack_i,
   input  logic               cmd_valid_i,
   input  logic [2:0]         cmd_op_i,
   input  logic [ID_W-1:0]    cmd_irq_i,
   output logic               grant_valid_o,
   output logic [ID_W-1:0]    grant_id_o,
   output logic [NUM_IRQ-1:0] isr_o
);
   localparam logic [ID_W-1:0] ONE        = ID_W'(1);
   localparam logic [ID_W-1:0] BASE_RESET = ID_W'(RESET_LOWEST + 1);

   // Elaboration-time parameter checks.
   if (NUM_IRQ < 2 || (NUM_IRQ & (NUM_IRQ - 1)) != 0) begin : g_bad_n
      $error("NUM_IRQ must be a power of two of at least 2");
   end
   if ((1 << ID_W) != NUM_IRQ) begin : g_bad_w
      $error("ID_W must equal log2(NUM_IRQ)");
   end
   if (RESET_LOWEST < 0 || RESET_LOWEST >= NUM_IRQ) begin : g_bad_low
      $error("RESET_LOWEST out of range");
   end

   logic [ID_W-1:0]    base_q, base_d;
   logic               auto_q, auto_d;
   logic [NUM_IRQ-1:0] pend;
   logic [NUM_IRQ-1:0] rot_pend, rot_isr;
   logic               any_req, any_isr;
   logic [ID_W-1:0]    pos_req, pos_isr;
   logic [ID_W-1:0]    top_isr_id;
   logic               clr_en;
   logic [ID_W-1:0]    clr_id;
   prio_op_e           op;

   assign pend = req_i & ~mask_i;

   irq_rotate #(.N(NUM_IRQ), .IW(ID_W)) i_rot_req (
      .vec_i (pend), .base_i (base_q), .rot_o (rot_pend));
   irq_rotate #(.N(NUM_IRQ), .IW(ID_W)) i_rot_isr (
      .vec_i (isr_o), .base_i (base_q), .rot_o (rot_isr));

   irq_first_set #(.N(NUM_IRQ), .IW(ID_W)) i_fs_req (
      .vec_i (rot_pend), .any_o (any_req), .pos_o (pos_req));
   irq_first_set #(.N(NUM_IRQ), .IW(ID_W)) i_fs_isr (
      .vec_i (rot_isr), .any_o (any_isr), .pos_o (pos_isr));

   // Grant only when the best request sits strictly ahead of all in-service bits.
   assign grant_valid_o = any_req && (!any_isr || (pos_req < pos_isr));
   assign grant_id_o    = base_q + pos_req;
   assign top_isr_id    = base_q + pos_isr;

   assign op = prio_op_e'(cmd_op_i);

   always_comb begin
      base_d = base_q;
      auto_d = auto_q;
      clr_en = 1'b0;
      clr_id = cmd_irq_i;
      if (cmd_valid_i) begin
         unique case (op)
            OP_NOP: ;
            OP_EOI_NS: begin
               clr_en = any_isr;
               clr_id = top_isr_id;
               if (auto_q && any_isr) base_d = top_isr_id + ONE;
            end
            OP_EOI_SPEC: clr_en = 1'b1;
            OP_ROT_NS: begin
               clr_en = any_isr;
               clr_id = top_isr_id;
               if (any_isr) base_d = top_isr_id + ONE;
            end
            OP_ROT_SPEC: begin
               clr_en = 1'b1;
               base_d = cmd_irq_i + ONE;
            end
            OP_SET_LOW:  base_d = cmd_irq_i + ONE;
            OP_AUTO_ON:  auto_d = 1'b1;
            OP_AUTO_OFF: auto_d = 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= BASE_RESET;
         auto_q <= 1'b0;
      end else begin
         base_q <= base_d;
         auto_q <= auto_d;
      end
   end

   irq_isr_bank #(.N(NUM_IRQ), .IW(ID_W)) i_isr (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en_i (ack_i && grant_valid_o),
      .set_id_i (grant_id_o),
      .clr_en_i (clr_en),
      .clr_id_i (clr_id),
      .isr_o    (isr_o)
   );
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk
   import irq_prio_pkg::*;
#(
   parameter int NUM_IRQ = 8,
   parameter int ID_W    = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] req_i,
   input logic [NUM_IRQ-1:0] mask_i,
   input logic               ack_i,
   input logic               cmd_valid_i,
   input logic [2:0]         cmd_op_i,
   input logic [ID_W-1:0]    cmd_irq_i,
   input logic               grant_valid_o,
   input logic [ID_W-1:0]    grant_id_o,
   input logic [NUM_IRQ-1:0] isr_o
);
   a_r2_grant_is_requested: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> req_i[grant_id_o]);

   a_r3_grant_not_masked: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> !mask_i[grant_id_o]);

   a_r4_grant_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> !isr_o[grant_id_o]);

   a_r3_all_masked_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_i & ~mask_i) == '0) |-> !grant_valid_o);

   a_r5_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && grant_valid_o) |=> isr_o[$past(grant_id_o)]);

   a_r6_spec_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && (cmd_op_i == OP_EOI_SPEC || cmd_op_i == OP_ROT_SPEC)
       && !(ack_i && grant_valid_o && grant_id_o == cmd_irq_i))
      |=> !isr_o[$past(cmd_irq_i)]);

   a_r8_set_low_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_op_i == OP_SET_LOW && !ack_i) |=> $stable(isr_o));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_i         (req_i),
   .mask_i        (mask_i),
   .ack_i         (ack_i),
   .cmd_valid_i   (cmd_valid_i),
   .cmd_op_i      (cmd_op_i),
   .cmd_irq_i     (cmd_irq_i),
   .grant_valid_o (grant_valid_o),
   .grant_id_o    (grant_id_o),
   .isr_o         (isr_o)
);

// File: tb/test_irq_prio_resolver.sv
module test_irq_prio_resolver;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_i = '0;
   logic [7:0] mask_i = '0;
   logic       ack_i = 1'b0;
   logic       cmd_valid_i = 1'b0;
   logic [2:0] cmd_op_i = '0;
   logic [2:0] cmd_irq_i = '0;
   logic       grant_valid_o;
   logic [2:0] grant_id_o;
   logic [7:0] isr_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   irq_prio_resolver i_irq_prio_resolver (
      .clk, .rst_n, .req_i, .mask_i, .ack_i, .cmd_valid_i, .cmd_op_i,
      .cmd_irq_i, .grant_valid_o, .grant_id_o, .isr_o);

   typedef struct packed {
      logic       cv;
      logic [2:0] op;
      logic [2:0] irq;
      logic [7:0] req;
      logic [7:0] mask;
      logic       ack;
      logic       ev;
      logic [2:0] eid;
      logic [7:0] eisr;   // in-service value before this cycle's edge
      logic [3:0] rq;     // requirement number for the message
   } vec_t;

   localparam int NV = 34;
   // Op codes: 0 nop, 1 eoi ns, 2 eoi spec, 3 rot ns, 4 rot spec, 5 set low, 6 auto on, 7 auto off
   localparam vec_t VECS [NV] = '{
      '{1'b0,3'd0,3'd0,8'hFF,8'h00,1'b0,1'b1,3'd0,8'h00,4'd1},  // R1 reset order
      '{1'b0,3'd0,3'd0,8'h28,8'h00,1'b0,1'b1,3'd3,8'h00,4'd2},  // R2
      '{1'b0,3'd0,3'd0,8'h28,8'h08,1'b0,1'b1,3'd5,8'h00,4'd3},  // R3
      '{1'b0,3'd0,3'd0,8'h28,8'h28,1'b0,1'b0,3'd0,8'h00,4'd3},  // R3 all masked
      '{1'b0,3'd0,3'd0,8'h20,8'h00,1'b1,1'b1,3'd5,8'h00,4'd5},  // R5 ack 5
      '{1'b0,3'd0,3'd0,8'h20,8'h00,1'b0,1'b0,3'd0,8'h20,4'd4},  // R4 equal blocks
      '{1'b0,3'd0,3'd0,8'h80,8'h00,1'b0,1'b0,3'd0,8'h20,4'd4},  // R4 lower blocks
      '{1'b0,3'd0,3'd0,8'h04,8'h00,1'b1,1'b1,3'd2,8'h20,4'd4},  // R4 nesting
      '{1'b0,3'd0,3'd0,8'h00,8'h00,1'b1,1'b0,3'd0,8'h24,4'd5},  // R5 ack no grant
      '{1'b1,3'd1,3'd0,8'h00,8'h00,1'b0,1'b0,3'd0,8'h24,4'd5},  // R5 isr unchanged
      '{1'b1,3'd2,3'd5,8'h00,8'h00,1'b0,1'b0,3'd0,8'h20,4'd7},  // R7 cleared bit 2
      '{1'b0,3'd0,3'd0,8'h00,8'h00,1'b0,1'b0,3'd0,8'h00,4'd6},  // R6 cleared bit 5
      '{1'b1,3'd5,3'd4,8'hFF,8'h00,1'b0,1'b1,3'd0,8'h00,4'd8},  // R8 lowest = 4
      '{1'b0,3'd0,3'd0,8'hFF,8'h00,1'b0,1'b1,3'd5,8'h00,4'd8},  // R8
      '{1'b0,3'd0,3'd0,8'h11,8'h00,1'b0,1'b1,3'd0,8'h00,4'd8},  // R8 wrap
      '{1'b0,3'd0,3'd0,8'h08,8'h00,1'b1,1'b1,3'd3,8'h00,4'd8},  // R8
      '{1'b0,3'd0,3'd0,8'h01,8'h00,1'b1,1'b1,3'd0,8'h08,4'd4},  // R4 rotated nesting
      '{1'b1,3'd1,3'd0,8'h00,8'h00,1'b0,1'b0,3'd0,8'h09,4'd7},  // R7 rotated
      '{1'b1,3'd4,3'd3,8'h00,8'h00,1'b0,1'b0,3'd0,8'h08,4'd7},  // R7 result
      '{1'b0,3'd0,3'd0,8'hFF,8'h00,1'b0,1'b1,3'd4,8'h00,4'd9},  // R9 base 4
      '{1'b0,3'd0,3'd0,8'h48,8'h00,1'b0,1'b1,3'd6,8'h00,4'd9},  // R9
      '{1'b0,3'd0,3'd0,8'h02,8'h00,1'b1,1'b1,3'd1,8'h00,4'd9},  // R9
      '{1'b0,3'd0,3'd0,8'h40,8'h00,1'b1,1'b1,3'd6,8'h02,4'd4},  // R4
      '{1'b1,3'd3,3'd0,8'h00,8'h00,1'b0,1'b0,3'd0,8'h42,4'd10}, // R10
      '{1'b0,3'd0,3'd0,8'hFF,8'h00,1'b0,1'b1,3'd7,8'h02,4'd10}, // R10 base 7
      '{1'b1,3'd2,3'd1,8'h00,8'h00,1'b0,1'b0,3'd0,8'h02,4'd10}, // R10
      '{1'b1,3'd6,3'd0,8'h00,8'h00,1'b0,1'b0,3'd0,8'h00,4'd6},  // R6
      '{1'b0,3'd0,3'd0,8'h03,8'h00,1'b1,1'b1,3'd0,8'h00,4'd11}, // R11
      '{1'b1,3'd1,3'd0,8'h00,8'h00,1'b0,1'b0,3'd0,8'h01,4'd11}, // R11 auto eoi
      '{1'b0,3'd0,3'd0,8'h03,8'h00,1'b0,1'b1,3'd1,8'h00,4'd11}, // R11 base 1
      '{1'b1,3'd7,3'd0,8'h03,8'h00,1'b0,1'b1,3'd1,8'h00,4'd11}, // R11 auto off
      '{1'b0,3'd0,3'd0,8'h10,8'h00,1'b1,1'b1,3'd4,8'h00,4'd11}, // R11
      '{1'b1,3'd1,3'd0,8'h00,8'h00,1'b0,1'b0,3'd0,8'h10,4'd11}, // R11 plain eoi
      '{1'b0,3'd0,3'd0,8'h09,8'h00,1'b0,1'b1,3'd3,8'h00,4'd11}  // R11 base kept
   };

   task automatic check(input string tag, input logic gv, input logic [2:0] gid,
                        input logic [7:0] isr, input logic ev, input logic [2:0] eid,
                        input logic [7:0] eisr);
      n_chk++;
      if (gv !== ev || (ev && gid !== eid) || isr !== eisr) begin
         n_bad++;
         $display("FAIL %s: got valid=%0b id=%0d isr=%02h, expected valid=%0b id=%0d isr=%02h",
                  tag, gv, gid, isr, ev, eid, eisr);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         cmd_valid_i = VECS[v].cv;
         cmd_op_i    = VECS[v].op;
         cmd_irq_i   = VECS[v].irq;
         req_i       = VECS[v].req;
         mask_i      = VECS[v].mask;
         ack_i       = VECS[v].ack;
         #2;
         check($sformatf("R%0d vector %0d", VECS[v].rq, v), grant_valid_o, grant_id_o,
               isr_o, VECS[v].ev, VECS[v].eid, VECS[v].eisr);
      end

      // R1: reset in the middle of a run restores the default order and clears service.
      @(negedge clk);
      cmd_valid_i = 1'b0; ack_i = 1'b1; req_i = 8'h80; mask_i = '0;
      @(negedge clk);
      ack_i = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1; req_i = 8'hFF;
      #2;
      check("R1 after reset", grant_valid_o, grant_id_o, isr_o, 1'b1, 3'd0, 8'h00);

      // R12: automatic rotation serves every line once before any repeats.
      @(negedge clk);
      cmd_valid_i = 1'b1; cmd_op_i = 3'd6;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         cmd_valid_i = 1'b0; ack_i = 1'b1;
         #2;
         check($sformatf("R12 service %0d", k), grant_valid_o, grant_id_o, isr_o,
               1'b1, 3'(k % 8), 8'h00);
         @(negedge clk);
         ack_i = 1'b0; cmd_valid_i = 1'b1; cmd_op_i = 3'd1;
      end
      @(negedge clk);
      cmd_valid_i = 1'b0;

      // R3: masked lines stay out even under rotation (base is 0 again here).
      mask_i = 8'h0F;
      #2;
      check("R3 masked under rotation", grant_valid_o, grant_id_o, isr_o, 1'b1, 3'd4, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule